// File: doc/BRIEF.md
# Two-Digit Decimal Adder

This block adds two packed decimal operands and returns their packed decimal sum in a single combinational path. Each operand carries `NDIG` decimal digits (two by default), one digit per 4-bit nibble, so the default operands and the result are 8 bits wide. No carry leaves the top digit, so with two digits the result is the sum modulo 100.

The adder is built from bit-level logic only. Bitwise operators and plain assignment drive a one-bit full adder. That full adder is chained into a ripple stage, and two ripple stages make up each digit cell. The first stage forms a 5-bit binary intermediate. A gate expression flags an intermediate above nine. That flag sets the digit carry and drives the second stage, which adds six to the low four bits. Six modulo sixteen equals minus ten, so the intermediates 0xA to 0xF fold back to 0 to 5. The same rule also repairs intermediates that overflowed bit 3. The digit cells ripple from least to most significant digit, and the top carry is dropped.

Top module: `bcd_add_core`

## Requirements
- R1: Digit k of each operand and of the result sits in bits [4k+3:4k], with digit 0 least significant, and each digit is the plain binary value 0 to 9. Nibble codes 0xA to 0xF are never applied.
- R2: For valid operands, every nibble of the result lies in the range 0 to 9.
- R3: Result digit k equals (a_k + b_k + c_k) mod 10. The carry into digit 0 is zero.
- R4: The carry into digit k+1 is set exactly when a_k + b_k + c_k exceeds nine. This covers intermediates with a binary carry out of bit 3 (for example 9+9) and intermediates from 0xA to 0xF (for example 5+5).
- R5: The carry out of the most significant digit is discarded, so operand totals of 100 or more wrap modulo 100 (99+99 gives 98, 50+50 gives 00, 99+01 gives 00).
- R6: The result is purely combinational. It follows a change of the operands within the same time step, with no clock edge in between.
- R7: An operand of zero is the identity: a + 00 returns a unchanged for every valid a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NDIG | First packed decimal operand |
| b_i | input | 4*NDIG | Second packed decimal operand |
| sum_o | output | 4*NDIG | Packed decimal sum modulo 10^NDIG |

## Verification
The assertions hold only while every nibble of both operands is a legal digit, and they are gated off whenever any nibble reads 0xA or above. No claim is made about illegal codes. The stimulus stays inside that domain by construction: it walks the two operands as decimal counts from 0 to 99 and converts each count to a packed nibble pair. The 10,000 legal pairs are therefore all applied, and none of the other bit patterns is.

// File: rtl/bcd_add_pkg.sv
`timescale 1ns/1ps
package bcd_add_pkg;
  localparam int DIG_W = 4;

  // An intermediate {carry, s3..s0} is above nine when it carried out of bit 3
  // or when bit 3 is set together with bit 2 or bit 1.
  function automatic logic dec_over(input logic [DIG_W:0] t);
    return t[4] | (t[3] & (t[2] | t[1]));
  endfunction

  // Operand of the correction stage: 0110 when the correction is needed.
  function automatic logic [DIG_W-1:0] fix_operand(input logic need);
    return {1'b0, need, need, 1'b0};
  endfunction
endpackage

// File: rtl/bcd_full_add.sv
`timescale 1ns/1ps
module bcd_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (ci & p);
endmodule

// File: rtl/bcd_ripple.sv
`timescale 1ns/1ps
module bcd_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    bcd_full_add fa_i (
      .a  (a[i]),
      .b  (b[i]),
      .ci (c[i]),
      .s  (s[i]),
      .co (c[i+1])
    );
  end

  assign co = c[W];
endmodule

// File: rtl/bcd_digit_add.sv
`timescale 1ns/1ps
module bcd_digit_add
  import bcd_add_pkg::*;
(
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  input  logic             ci,
  output logic [DIG_W-1:0] s,
  output logic             co,
  output logic             fix_co
);
  logic [DIG_W-1:0] raw_s;
  logic             raw_c;
  logic [DIG_W-1:0] fix_b;

  // Stage one: plain binary sum of the two digits and the incoming carry.
  bcd_ripple #(.W(DIG_W)) raw_add (
    .a  (a),
    .b  (b),
    .ci (ci),
    .s  (raw_s),
    .co (raw_c)
  );

  assign co    = dec_over({raw_c, raw_s});
  assign fix_b = fix_operand(co);

  // Stage two: add six when the digit overflowed; its carry is not part of the sum.
  bcd_ripple #(.W(DIG_W)) fix_add (
    .a  (raw_s),
    .b  (fix_b),
    .ci (1'b0),
    .s  (s),
    .co (fix_co)
  );
endmodule

// File: rtl/bcd_add_core.sv
`timescale 1ns/1ps
module bcd_add_core
  import bcd_add_pkg::*;
#(
  parameter int NDIG = 2,
  localparam int W = NDIG * DIG_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // dcarry[k] enters digit k; dcarry[NDIG] leaves the top digit and is dropped.
  logic [NDIG:0]   dcarry;
  logic [NDIG-1:0] fix_co;

  assign dcarry[0] = 1'b0;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    bcd_digit_add dig_i (
      .a      (a_i[k*DIG_W +: DIG_W]),
      .b      (b_i[k*DIG_W +: DIG_W]),
      .ci     (dcarry[k]),
      .s      (sum_o[k*DIG_W +: DIG_W]),
      .co     (dcarry[k+1]),
      .fix_co (fix_co[k])
    );
  end
endmodule

// File: rtl/bcd_add_chk.sv
`timescale 1ns/1ps
module bcd_add_chk #(
  parameter int NDIG = 2,
  localparam int W = NDIG * 4
) (
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [W-1:0]    sum_o,
  input logic [NDIG:0]   dcarry,
  input logic [NDIG-1:0] fix_co
);
  // Assertions apply only while every operand nibble is a legal digit (R1).
  logic [2*NDIG-1:0] nib_ok;
  logic              ops_ok;

  for (genvar k = 0; k < NDIG; k++) begin : g_ok
    assign nib_ok[2*k]   = (a_i[4*k +: 4] <= 4'd9);
    assign nib_ok[2*k+1] = (b_i[4*k +: 4] <= 4'd9);
  end
  assign ops_ok = &nib_ok;

  for (genvar k = 0; k < NDIG; k++) begin : g_chk
    logic [4:0] raw;
    logic [3:0] out_d;
    assign raw   = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]} + {4'd0, dcarry[k]};
    assign out_d = sum_o[4*k +: 4];

    always_comb begin
      if (ops_ok) begin
        a_r2_digit_range: assert (out_d <= 4'd9)
          else $error("R2 digit %0d out of range: %h", k, out_d);
        a_r3_digit_value: assert (out_d == 4'(raw % 5'd10))
          else $error("R3 digit %0d got %h from raw %0d", k, out_d, raw);
        a_r4_digit_carry: assert (dcarry[k+1] == (raw > 5'd9))
          else $error("R4 digit %0d carry %b for raw %0d", k, dcarry[k+1], raw);
        // R4: the add-six stage overflows only for intermediates 10 to 15.
        a_r4_fix_carry: assert (fix_co[k] == ((raw >= 5'd10) && (raw <= 5'd15)))
          else $error("R4 digit %0d correction carry %b for raw %0d", k, fix_co[k], raw);
      end
    end
  end

  always_comb begin
    if (ops_ok && (b_i == '0)) begin
      a_r7_zero_identity: assert (sum_o == a_i)
        else $error("R7 %h + 0 gave %h", a_i, sum_o);
    end
  end
endmodule

bind bcd_add_core bcd_add_chk #(.NDIG(NDIG)) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .sum_o  (sum_o),
  .dcarry (dcarry),
  .fix_co (fix_co)
);

// File: tb/bcd_add_core_tb_top.sv
`timescale 1ns/1ps
module bcd_add_core_tb_top;
  localparam int NDIG = 2;
  localparam int W    = NDIG * 4;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] exp;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_s, b_s;
  logic [W-1:0] sum_s;
  item_t        q[$];
  item_t        it;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  bcd_add_core #(.NDIG(NDIG)) dut_i (
    .a_i   (a_s),
    .b_i   (b_s),
    .sum_o (sum_s)
  );

  function automatic int to_int(input logic [W-1:0] v);
    return 10 * int'(v[7:4]) + int'(v[3:0]);
  endfunction

  function automatic logic [W-1:0] to_pack(input int n);
    logic [W-1:0] r;
    r[7:4] = 4'((n / 10) % 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  // Reference model: convert to integers, add, wrap, convert back.
  function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return to_pack((to_int(a) + to_int(b)) % 100);
  endfunction

  function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b);
    if (to_int(a) + to_int(b) >= 100)      return "R5";
    if (b == '0)                           return "R7";
    if (int'(a[3:0]) + int'(b[3:0]) > 9)   return "R4";
    return "R3";
  endfunction

  task automatic check(input string r, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %h + %h actual %h expected %h", r, a, b, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string r);
    item_t x;
    @(negedge clk);
    a_s   = a;
    b_s   = b;
    x.a   = a;
    x.b   = b;
    x.exp = ref_sum(a, b);
    x.req = r;
    q.push_back(x);
  endtask

  // Monitor: one scoreboard item per rising edge, half a cycle after the drive.
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      it = q.pop_front();
      check(it.req, sum_s, it.exp, it.a, it.b);
      n_chk++;
      if ((sum_s[3:0] > 4'd9) || (sum_s[7:4] > 4'd9)) begin
        n_bad++;
        $display("FAIL R2: %h + %h actual %h expected digits 0..9", it.a, it.b, sum_s);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_s   = '0;
    b_s   = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", sum_s, 8'h00, a_s, b_s);
    rst_n = 1'b1;

    // R1: field positions, tens in the upper nibble.
    drive(8'h10, 8'h01, "R1");
    drive(8'h30, 8'h05, "R1");
    // R4: carry from both intermediate kinds.
    drive(8'h09, 8'h09, "R4");
    drive(8'h05, 8'h05, "R4");
    drive(8'h18, 8'h04, "R4");
    // R5: wrap at one hundred.
    drive(8'h99, 8'h99, "R5");
    drive(8'h50, 8'h50, "R5");
    drive(8'h99, 8'h01, "R5");

    // Exhaustive sweep of every legal operand pair.
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < 100; j++) begin
        drive(to_pack(i), to_pack(j), tag_of(to_pack(i), to_pack(j)));
      end
    end

    wait (q.size() == 0);
    @(negedge clk);

    // R6: change operands between edges and look before any rising edge.
    #0.5;
    a_s = 8'h47;
    b_s = 8'h38;
    #0.5;
    check("R6", sum_s, 8'h85, a_s, b_s);
    a_s = 8'h62;
    b_s = 8'h59;
    #0.5;
    check("R6", sum_s, 8'h21, a_s, b_s);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule